// File: doc/BRIEF.md
# Static Memory Bank Timing Engine

This block runs single read and write cycles on one asynchronous static-memory bank. A requester hands over one access at a time through a valid/ready handshake: a byte address, write data, per-lane byte enables and a direction flag. The engine then drives the chip select, the output-enable (read) strobe, the per-lane write strobes, the per-lane byte-select lines and the address and data pins. Each access moves through three phases in turn: setup, pulse and hold. Reads and writes each have their own setup, pulse and hold counts.

The pulse phase is lengthened by a programmable number of wait states. When external waiting is enabled, the pulse phase is also stretched while the wait input is high on its last cycle. Read data is sampled on the final pulse cycle and returned with a one-cycle done pulse. After a read, a programmable float interval must run out before the next access is accepted, so the bus has time to turn around. A read that falls in the same page as the previous read can use a shorter page pulse, which gives fast asynchronous page bursts. The data width is set by a parameter (8, 16 or 32 bits, one lane per byte). Writes either pulse one write strobe per enabled lane, or pulse a common strobe and mark the lanes with byte-select lines.

Top module: `smc_bank_seq`

## Requirements
- R1: During and right after reset, chip select, the read strobe, all write strobes and all byte-select lines are high (inactive). The data drive enable and done are low, and ready is high.
- R2: An access is accepted on a clock edge where req_valid and req_ready are both high. req_ready is high only when the engine is idle and no float interval is pending. After a write, ready returns S+L+H cycles after the accepting edge.
- R3: Chip select is low for exactly S+L+H consecutive cycles, starting the cycle after acceptance. S and H are the setup and hold counts for the access direction, and L is the pulse length.
- R4: The strobe for the access direction (read strobe for reads, write strobes for writes) goes low S cycles after chip select goes low. It stays low for L = max(P,1)+W cycles, where P is that direction's pulse count and W is the wait-state count. The read strobe and the write strobes are never low together.
- R5: With external waiting enabled, a high wait input on the last pulse cycle repeats that cycle. With waiting disabled, the wait input has no effect on any timing.
- R6: Read data is sampled from mem_din on the last pulse cycle. rsp_done is high for exactly one cycle, in the cycle after the last pulse cycle, and rsp_rdata holds the sampled value from then on.
- R7: After a read, the next acceptance is held off until max(H,F) cycles after the last pulse cycle, where F is the float count. The data drive enable stays low while the float interval runs. Writes ignore F.
- R8: In byte-write mode (cfg_lane_sel=0), bit i of mem_we_n goes low during the pulse only when bit i of the byte enable is set, and all byte-select lines stay high.
- R9: In byte-select mode (cfg_lane_sel=1), all write strobe bits pulse together. While chip select is low, byte-select bit i is low for writes whose enable bit i is set, and all byte-select bits are low for reads.
- R10: With page mode on, a read whose address shifted right by 2+cfg_page_size matches that of the previous completed read uses max(cfg_page_pulse,1)+W as its pulse length. cfg_page_size values 0, 1, 2, 3 select 4, 8, 16 and 32 byte pages. A completed write, or a read completed with page mode off, ends the page.
- R11: While chip select is low for a write, mem_doe is high and mem_dout carries the write data. mem_doe is low for reads. mem_addr is steady for the whole chip-select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_setup | input | CW | Read setup cycles |
| cfg_rd_pulse | input | CW | Read pulse cycles (0 treated as 1) |
| cfg_rd_hold | input | CW | Read hold cycles |
| cfg_wr_setup | input | CW | Write setup cycles |
| cfg_wr_pulse | input | CW | Write pulse cycles (0 treated as 1) |
| cfg_wr_hold | input | CW | Write hold cycles |
| cfg_page_pulse | input | CW | Pulse cycles for a read hitting the open page |
| cfg_wait_states | input | CW | Extra cycles added to every pulse |
| cfg_float | input | CW | Turnaround cycles after a read |
| cfg_wait_en | input | 1 | Honour mem_wait |
| cfg_lane_sel | input | 1 | 0: per-lane write strobes, 1: common strobe plus byte selects |
| cfg_page_en | input | 1 | Enable page-mode reads |
| cfg_page_size | input | 2 | Page size code: 4 << code bytes |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Engine can accept an access |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Last read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | DW/8 | Write strobes, active low |
| mem_bs_n | output | DW/8 | Byte-select lines, active low |
| mem_addr | output | AW | Address pins |
| mem_dout | output | DW | Data to memory |
| mem_doe | output | 1 | Data drive enable |
| mem_din | input | DW | Data from memory |
| mem_wait | input | 1 | External wait request |

## Verification
All timings are counted from the accepting edge, and the bench samples at the falling edge that follows each rising edge. Chip select is first seen low at sample 1 and the strobe at sample S+1. Done appears at sample S+L+1, and ready comes back at sample S+L+H+1 for writes and S+L+max(H,F)+1 for reads. The bench works out each index from the configured counts and compares it with the sample at which it first sees the event. It also counts the low samples of each strobe and compares those counts with the expected widths. The wait input is driven per pulse cycle at the falling edge, so the bench can work out in advance which final-cycle sample sees it high.

// File: rtl/smc_bank_seq.sv
module smc_bank_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_rd_setup,
  input  logic [CW-1:0] cfg_rd_pulse,
  input  logic [CW-1:0] cfg_rd_hold,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic [CW-1:0] cfg_wr_pulse,
  input  logic [CW-1:0] cfg_wr_hold,
  input  logic [CW-1:0] cfg_page_pulse,
  input  logic [CW-1:0] cfg_wait_states,
  input  logic [CW-1:0] cfg_float,
  input  logic          cfg_wait_en,
  input  logic          cfg_lane_sel,
  input  logic          cfg_page_en,
  input  logic [1:0]    cfg_page_size,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic [DW/8-1:0] mem_we_n,
  output logic [DW/8-1:0] mem_bs_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din,
  input  logic          mem_wait
);
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD} st_t;

  st_t           st;
  logic [CW:0]   cnt;
  logic [CW:0]   plen_q;
  logic [CW-1:0] hold_q;
  logic [CW-1:0] fcnt;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [NB-1:0] be_q;
  logic [AW-1:0] tag_q;
  logic [AW-1:0] pg_tag;
  logic          pg_vld;

  wire [AW-1:0]  req_tag  = req_addr >> (3'd2 + {1'b0, cfg_page_size});
  wire           page_hit = cfg_page_en && !req_we && pg_vld && (req_tag == pg_tag);
  wire [CW-1:0]  pbase    = req_we ? cfg_wr_pulse : (page_hit ? cfg_page_pulse : cfg_rd_pulse);
  wire [CW:0]    plen     = (pbase == '0 ? (CW+1)'(1) : {1'b0, pbase}) + {1'b0, cfg_wait_states};
  wire [CW-1:0]  slen     = req_we ? cfg_wr_setup : cfg_rd_setup;
  wire           accept   = req_valid && req_ready;
  wire           last_pul = (st == ST_PULSE) && (cnt <= 1) && !(cfg_wait_en && mem_wait);

  assign req_ready = (st == ST_IDLE) && (fcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      plen_q    <= '0;
      hold_q    <= '0;
      fcnt      <= '0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wd_q      <= '0;
      be_q      <= '0;
      tag_q     <= '0;
      pg_tag    <= '0;
      pg_vld    <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (fcnt != '0) fcnt <= fcnt - 1'b1;
      case (st)
        ST_IDLE: if (accept) begin
          we_q   <= req_we;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          be_q   <= req_be;
          tag_q  <= req_tag;
          plen_q <= plen;
          hold_q <= req_we ? cfg_wr_hold : cfg_rd_hold;
          if (slen != '0) begin
            st  <= ST_SETUP;
            cnt <= {1'b0, slen};
          end else begin
            st  <= ST_PULSE;
            cnt <= plen;
          end
        end
        ST_SETUP: begin
          if (cnt == 1) begin
            st  <= ST_PULSE;
            cnt <= plen_q;
          end else cnt <= cnt - 1'b1;
        end
        ST_PULSE: begin
          if (cnt > 1) cnt <= cnt - 1'b1;
          else if (last_pul) begin
            rsp_done <= 1'b1;
            if (!we_q) begin
              rsp_rdata <= mem_din;
              fcnt      <= cfg_float;
              pg_vld    <= cfg_page_en;
              pg_tag    <= tag_q;
            end else pg_vld <= 1'b0;
            if (hold_q != '0) begin
              st  <= ST_HOLD;
              cnt <= {1'b0, hold_q};
            end else st <= ST_IDLE;
          end
        end
        default: begin
          if (cnt == 1) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  wire active = (st != ST_IDLE);
  wire wstb   = (st == ST_PULSE) && we_q;

  assign mem_cs_n = !active;
  assign mem_oe_n = !((st == ST_PULSE) && !we_q);
  assign mem_we_n = cfg_lane_sel ? {NB{!wstb}} : ~({NB{wstb}} & be_q);
  assign mem_bs_n = (cfg_lane_sel && active) ? (we_q ? ~be_q : '0) : '1;
  assign mem_addr = addr_q;
  assign mem_dout = wd_q;
  assign mem_doe  = active && we_q;

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_cs_n); // R2
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !(&mem_we_n)) |-> !mem_cs_n); // R3
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> ((&mem_we_n) && !mem_doe)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R6
  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt != '0) |-> !mem_doe); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R11
endmodule

// File: tb/test_smc_bank_seq.sv
module test_smc_bank_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_rd_setup = 0, cfg_rd_pulse = 0, cfg_rd_hold = 0;
  logic [3:0] cfg_wr_setup = 0, cfg_wr_pulse = 0, cfg_wr_hold = 0;
  logic [3:0] cfg_page_pulse = 0, cfg_wait_states = 0, cfg_float = 0;
  logic cfg_wait_en = 0, cfg_lane_sel = 0, cfg_page_en = 0;
  logic [1:0] cfg_page_size = 0;
  logic req_valid = 0, req_we = 0;
  logic req_ready;
  logic [7:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0] req_be = 2'b11;
  logic rsp_done;
  logic [15:0] rsp_rdata;
  logic mem_cs_n, mem_oe_n, mem_doe;
  logic [1:0] mem_we_n, mem_bs_n;
  logic [7:0] mem_addr;
  logic [15:0] mem_dout, mem_din;
  logic mem_wait = 0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_din = mem_oe_n ? 16'hDEAD : {mem_addr, ~mem_addr};

  smc_bank_seq i_smc_bank_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_pulse(cfg_wr_pulse), .cfg_wr_hold(cfg_wr_hold),
    .cfg_page_pulse(cfg_page_pulse), .cfg_wait_states(cfg_wait_states), .cfg_float(cfg_float),
    .cfg_wait_en(cfg_wait_en), .cfg_lane_sel(cfg_lane_sel), .cfg_page_en(cfg_page_en),
    .cfg_page_size(cfg_page_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .mem_wait(mem_wait)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic txn(input logic we, input logic [7:0] a, input logic [15:0] wd,
                     input logic [1:0] be, input int s, input int l, input int h,
                     input int f, input int wx, input string ltag);
    int cs_cnt = 0, pul = 0, pfirst = -1, dk = -1, rk = -1, wi = 0, ndone = 0, erk;
    bit lane_ok = 1, data_ok = 1, strobe;
    logic [15:0] rd = 0;
    logic [1:0] exp_we, exp_bs;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    exp_bs = cfg_lane_sel ? (we ? ~be : 2'b00) : 2'b11;
    exp_we = cfg_lane_sel ? 2'b00 : ~be;
    @(negedge clk);
    req_valid = 0;
    for (int k = 1; k < 80 && rk < 0; k++) begin
      if (k > 1) @(negedge clk);
      strobe = we ? (mem_we_n != 2'b11) : !mem_oe_n;
      if (!mem_cs_n) begin
        cs_cnt++;
        if (mem_bs_n != exp_bs) lane_ok = 0;
        if (mem_doe != we) data_ok = 0;
        if (we && mem_dout != wd) data_ok = 0;
        if (mem_addr != a) data_ok = 0;
      end
      if (strobe) begin
        if (pfirst < 0) pfirst = k;
        pul++;
        if (we && mem_we_n != exp_we) lane_ok = 0;
        mem_wait = (wi < wx);
        wi++;
      end else mem_wait = 0;
      if (rsp_done) begin
        ndone++;
        if (dk < 0) begin dk = k; rd = rsp_rdata; end
      end
      if (req_ready) rk = k;
    end
    mem_wait = 0;
    chk(cs_cnt == s + l + h, "R3 chip select width", cs_cnt, s + l + h);
    chk(pfirst == s + 1, "R4 strobe start", pfirst, s + 1);
    chk(pul == l, ltag, pul, l);
    chk(dk == s + l + 1, "R6 done timing", dk, s + l + 1);
    chk(ndone == 1, "R6 done single", ndone, 1);
    if (!we) chk(rd == {a, ~a}, "R6 read data", int'(rd), int'({a, ~a}));
    erk = s + l + (we ? h : (h > f ? h : f)) + 1;
    chk(rk == erk, we ? "R2 ready after write" : "R7 float turnaround", rk, erk);
    chk(lane_ok, cfg_lane_sel ? "R9 byte select lanes" : "R8 byte write lanes", int'(lane_ok), 1);
    chk(data_ok, "R11 data drive and address", int'(data_ok), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n == 2'b11 && mem_bs_n == 2'b11 && !mem_doe && !rsp_done,
        "R1 reset outputs", 0, 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !rsp_done, "R1 ready after reset", int'(req_ready), 1);

    for (int we = 0; we < 2; we++)
      for (int s = 0; s < 3; s++)
        for (int p = 0; p < 4; p++)
          for (int h = 0; h < 3; h++)
            for (int w = 0; w < 2; w++)
              for (int f = 0; f < 4; f++) begin
                if (we != 0) begin
                  cfg_wr_setup = 4'(s); cfg_wr_pulse = 4'(p); cfg_wr_hold = 4'(h);
                  cfg_rd_setup = 3; cfg_rd_pulse = 3; cfg_rd_hold = 3;
                end else begin
                  cfg_rd_setup = 4'(s); cfg_rd_pulse = 4'(p); cfg_rd_hold = 4'(h);
                  cfg_wr_setup = 3; cfg_wr_pulse = 3; cfg_wr_hold = 3;
                end
                cfg_wait_states = 4'(w); cfg_float = 4'(f); cfg_page_pulse = 2;
                n++;
                txn(we[0], 8'(n * 37), 16'(n * 913), 2'b11, s, (p == 0 ? 1 : p) + w, h, f, 0,
                    "R4 strobe width");
              end

    cfg_rd_setup = 1; cfg_rd_pulse = 2; cfg_rd_hold = 1; cfg_wait_states = 0; cfg_float = 0;
    cfg_wr_setup = 1; cfg_wr_pulse = 2; cfg_wr_hold = 1;
    cfg_wait_en = 1;
    for (int x = 0; x < 6; x++)
      txn(1'b0, 8'(x + 5), 16'h0, 2'b11, 1, (x + 1 > 2 ? x + 1 : 2), 1, 0, x, "R5 wait stretch");
    txn(1'b1, 8'h21, 16'hA5C3, 2'b11, 1, 4, 1, 0, 3, "R5 wait stretch write");
    cfg_wait_en = 0;
    txn(1'b0, 8'h22, 16'h0, 2'b11, 1, 2, 1, 0, 4, "R5 wait ignored");

    cfg_wr_setup = 0; cfg_wr_pulse = 1; cfg_wr_hold = 1;
    cfg_lane_sel = 0;
    for (int b = 1; b < 4; b++) txn(1'b1, 8'(b), 16'h1234 + 16'(b), 2'(b), 0, 1, 1, 0, 0, "R8 strobe width");
    cfg_lane_sel = 1;
    for (int b = 0; b < 4; b++) txn(1'b1, 8'(b + 9), 16'h4321 + 16'(b), 2'(b), 0, 1, 1, 0, 0, "R9 strobe width");
    txn(1'b0, 8'h40, 16'h0, 2'b01, 1, 2, 1, 0, 0, "R9 read strobe width");
    cfg_lane_sel = 0;

    cfg_rd_setup = 0; cfg_rd_pulse = 4; cfg_rd_hold = 0; cfg_page_pulse = 1; cfg_float = 0;
    cfg_page_en = 1;
    for (int pg = 0; pg < 4; pg++) begin
      int sz;
      sz = 4 << pg;
      cfg_page_size = 2'(pg);
      txn(1'b1, 8'h00, 16'h0, 2'b11, 0, 1, 1, 0, 0, "R10 write");
      txn(1'b0, 8'd64, 16'h0, 2'b11, 0, 4, 0, 0, 0, "R10 page miss");
      txn(1'b0, 8'(64 + sz - 2), 16'h0, 2'b11, 0, 1, 0, 0, 0, "R10 page hit");
      txn(1'b0, 8'(64 + sz), 16'h0, 2'b11, 0, 4, 0, 0, 0, "R10 next page miss");
      txn(1'b0, 8'(64 + sz), 16'h0, 2'b11, 0, 1, 0, 0, 0, "R10 next page hit");
      txn(1'b1, 8'(64 + sz), 16'h0, 2'b11, 0, 1, 1, 0, 0, "R10 write closes page");
      txn(1'b0, 8'(64 + sz), 16'h0, 2'b11, 0, 4, 0, 0, 0, "R10 miss after write");
    end
    cfg_page_en = 0;
    txn(1'b0, 8'd64, 16'h0, 2'b11, 0, 4, 0, 0, 0, "R10 page off");
    txn(1'b0, 8'd64, 16'h0, 2'b11, 0, 4, 0, 0, 0, "R10 page off repeat");
    cfg_page_en = 1;
    txn(1'b0, 8'd64, 16'h0, 2'b11, 0, 4, 0, 0, 0, "R10 page reopened miss");
    txn(1'b0, 8'd66, 16'h0, 2'b11, 0, 1, 0, 0, 0, "R10 page reopened hit");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule